// File: doc/BRIEF.md
# Shared Microcode RAM Controller

This block owns a 1024-word by 16-bit RAM that is shared between a general host bus and two timer microengines. In normal operation the host loads and inspects the array through a valid/ready port with a one-cycle response. Once microcode is in place, either microengine can raise its emulation input. Ownership of the whole array then moves to the engines. Each engine has its own read port, and both ports can fetch one word per cycle in the same cycle.

While any emulation input is high, the host port still completes every transfer, but it does nothing to the array. Writes are discarded, and reads finish with an error flag and zero data. The host-side disable bit only gates host traffic, so it has no influence on the engines. A stop-mode request takes the array into a low-power state and is acknowledged one cycle later. The block refuses the request while either engine owns the array. While stopped, all accesses are rejected until the request is removed. The freeze input is accepted but changes nothing, so host and engine traffic carry on during freeze.

Top module: `ucode_ram_ctrl`

## Requirements
- R1: During reset, host_ready, host_rsp_valid, host_err, stop_ack, eng0_data and eng1_data are all 0. host_ready is 1 from the first clock edge after reset is released.
- R2: A host transfer is accepted on a clock edge where host_valid and host_ready are both 1. Its response (host_rsp_valid=1) appears after that same edge and lasts one cycle. When the transfer is permitted, a write (host_we=1) stores host_wdata and responds with err 0 and data 0. A read responds with err 0 and the stored word.
- R3: If either bit of emu_mode is 1 when a host transfer is accepted, the transfer responds with host_err=1 and host_rdata=0, and a write leaves the array unchanged.
- R4: If cfg_disable is 1 and emu_mode is 0 when a host transfer is accepted, the transfer responds with host_err=1 and host_rdata=0, and a write is discarded.
- R5: cfg_disable has no effect on engine reads.
- R6: Engine i reads when eng_en[i] and emu_mode[i] are both 1 and the block is not stopped. The addressed word appears on its data port after that edge. Both engines can read different addresses in the same cycle.
- R7: An engine's data output is 0 after any edge at which that engine's eng_en or emu_mode bit was 0.
- R8: stop_ack becomes 1 after the first edge at which stop_req is 1 and emu_mode is 0. It stays 1 while stop_req stays 1, and it becomes 0 after the first edge at which stop_req is 0.
- R9: While either emu_mode bit is 1, a stop request is not taken, and stop_ack stays 0.
- R10: While stop_ack is 1, host transfers respond with host_err=1 and data 0, writes are discarded, and both engine outputs read 0.
- R11: freeze has no effect on host or engine behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host transfer request |
| host_ready | output | 1 | Host port can accept a transfer |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rsp_valid | output | 1 | Response strobe, one cycle per accepted transfer |
| host_rdata | output | 16 | Read data, 0 on writes and refused transfers |
| host_err | output | 1 | Transfer was refused |
| cfg_disable | input | 1 | Blocks host access to the array |
| emu_mode | input | 2 | Emulation request, one bit per engine |
| freeze | input | 1 | Debug freeze, no effect |
| stop_req | input | 1 | Low-power stop request |
| stop_ack | output | 1 | Array is stopped |
| eng_en | input | 2 | Fetch enable, one bit per engine |
| eng0_addr | input | 10 | Engine 0 fetch address |
| eng1_addr | input | 10 | Engine 1 fetch address |
| eng0_data | output | 16 | Engine 0 fetched word |
| eng1_data | output | 16 | Engine 1 fetched word |

## Verification
A wrong ownership decision shows up in the response cycle right after the accepting edge. A refused transfer would carry data or lack its error flag, and a dropped write that leaked into the array would show up on the next permitted read of that address. Faults in the stop state machine show on stop_ack one edge after stop_req or emu_mode changes. Engine gating faults show on the engine data ports one edge after a fetch. The scoreboard compares every response against its queued expectation, so a missing or extra response is caught at once.

// File: rtl/ucram_pkg.sv
package ucram_pkg;
  localparam int NUM_ENG = 2;

  typedef enum logic {
    PWR_RUN  = 1'b0,
    PWR_STOP = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/ucram_array.sv
// Storage: one write port, two registered read ports (block RAM friendly).
module ucram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr0,
  input  logic [ADDR_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata0 <= mem[raddr0];
    rdata1 <= mem[raddr1];
  end
endmodule

// File: rtl/ucram_power.sv
// Stop-mode sequencer: entry refused while any engine owns the array.
module ucram_power (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic emu_any,
  output logic stopped
);
  import ucram_pkg::*;

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PWR_RUN:  if (stop_req && !emu_any) state_d = PWR_STOP;
      PWR_STOP: if (!stop_req)            state_d = PWR_RUN;
      default:                            state_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PWR_RUN;
    else     state_q <= state_d;
  end

  assign stopped = (state_q == PWR_STOP);
endmodule

// File: rtl/ucram_host_gate.sv
// Host handshake: every transfer completes; permission decided at acceptance.
module ucram_host_gate (
  input  logic clk,
  input  logic rst,
  input  logic host_valid,
  input  logic host_we,
  input  logic emu_any,
  input  logic cfg_disable,
  input  logic stopped,
  output logic host_ready,
  output logic mem_we,
  output logic rsp_valid,
  output logic rsp_err,
  output logic rsp_rd_ok
);
  logic accept;
  logic permit;

  assign accept = host_valid && host_ready;
  assign permit = !emu_any && !cfg_disable && !stopped;
  assign mem_we = accept && permit && host_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ready <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rd_ok  <= 1'b0;
    end else begin
      host_ready <= 1'b1;
      rsp_valid  <= accept;
      rsp_err    <= accept && !permit;
      rsp_rd_ok  <= accept && permit && !host_we;
    end
  end
endmodule

// File: rtl/ucode_ram_ctrl.sv
module ucode_ram_ctrl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          host_valid,
  output logic                          host_ready,
  input  logic                          host_we,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [DATA_W-1:0]             host_wdata,
  output logic                          host_rsp_valid,
  output logic [DATA_W-1:0]             host_rdata,
  output logic                          host_err,
  input  logic                          cfg_disable,
  input  logic [ucram_pkg::NUM_ENG-1:0] emu_mode,
  input  logic                          freeze,
  input  logic                          stop_req,
  output logic                          stop_ack,
  input  logic [ucram_pkg::NUM_ENG-1:0] eng_en,
  input  logic [ADDR_W-1:0]             eng0_addr,
  input  logic [ADDR_W-1:0]             eng1_addr,
  output logic [DATA_W-1:0]             eng0_data,
  output logic [DATA_W-1:0]             eng1_data
);
  import ucram_pkg::*;

  logic              emu_any;
  logic              stopped;
  logic              mem_we;
  logic              rsp_rd_ok;
  logic [ADDR_W-1:0] raddr0;
  logic [DATA_W-1:0] q0, q1;
  logic [NUM_ENG-1:0] eng_ok_q;
  logic [DATA_W-1:0] eng_q [NUM_ENG];

  assign emu_any = |emu_mode;
  // Port 0 is shared: host while it owns the array, engine 0 otherwise.
  assign raddr0  = emu_any ? eng0_addr : host_addr;

  ucram_power u_pwr (
    .clk      (clk),
    .rst      (rst),
    .stop_req (stop_req),
    .emu_any  (emu_any),
    .stopped  (stopped)
  );

  ucram_host_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .host_valid  (host_valid),
    .host_we     (host_we),
    .emu_any     (emu_any),
    .cfg_disable (cfg_disable),
    .stopped     (stopped),
    .host_ready  (host_ready),
    .mem_we      (mem_we),
    .rsp_valid   (host_rsp_valid),
    .rsp_err     (host_err),
    .rsp_rd_ok   (rsp_rd_ok)
  );

  ucram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .we     (mem_we),
    .waddr  (host_addr),
    .wdata  (host_wdata),
    .raddr0 (raddr0),
    .raddr1 (eng1_addr),
    .rdata0 (q0),
    .rdata1 (q1)
  );

  assign eng_q[0] = q0;
  assign eng_q[1] = q1;

  for (genvar i = 0; i < NUM_ENG; i++) begin : g_eng
    always_ff @(posedge clk) begin
      if (rst) eng_ok_q[i] <= 1'b0;
      else     eng_ok_q[i] <= eng_en[i] && emu_mode[i] && !stopped;
    end
  end

  assign host_rdata = rsp_rd_ok   ? q0       : '0;
  assign eng0_data  = eng_ok_q[0] ? eng_q[0] : '0;
  assign eng1_data  = eng_ok_q[1] ? eng_q[1] : '0;
  assign stop_ack   = stopped;
endmodule

// File: rtl/ucram_checker.sv
module ucram_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_rsp_valid,
  input logic [DATA_W-1:0] host_rdata,
  input logic              host_err,
  input logic              cfg_disable,
  input logic [1:0]        emu_mode,
  input logic              freeze,
  input logic              stop_req,
  input logic              stop_ack,
  input logic [1:0]        eng_en,
  input logic [DATA_W-1:0] eng0_data,
  input logic [DATA_W-1:0] eng1_data
);
  logic accept;
  assign accept = host_valid && host_ready;

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    accept |=> host_rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !host_rsp_valid);
  a_r3_emu_refuses_host: assert property (@(posedge clk) disable iff (rst)
    accept && (|emu_mode) |=> host_err && host_rdata == '0);
  a_r4_disable_refuses_host: assert property (@(posedge clk) disable iff (rst)
    accept && cfg_disable |=> host_err && host_rdata == '0);
  a_r10_stopped_refuses_host: assert property (@(posedge clk) disable iff (rst)
    accept && stop_ack |=> host_err && host_rdata == '0);
  a_r10_stopped_eng_zero: assert property (@(posedge clk) disable iff (rst)
    stop_ack |=> eng0_data == '0 && eng1_data == '0);
  a_r8_ack_rise: assert property (@(posedge clk) disable iff (rst)
    stop_req && !(|emu_mode) |=> stop_ack);
  a_r8_ack_fall: assert property (@(posedge clk) disable iff (rst)
    !stop_req |=> !stop_ack);
  a_r9_no_stop_in_emu: assert property (@(posedge clk) disable iff (rst)
    (|emu_mode) && !stop_ack |=> !stop_ack);
  a_r7_eng0_gated: assert property (@(posedge clk) disable iff (rst)
    !(eng_en[0] && emu_mode[0]) |=> eng0_data == '0);
  a_r7_eng1_gated: assert property (@(posedge clk) disable iff (rst)
    !(eng_en[1] && emu_mode[1]) |=> eng1_data == '0);
  a_r11_freeze_no_reject: assert property (@(posedge clk) disable iff (rst)
    accept && freeze && !(|emu_mode) && !cfg_disable && !stop_ack |=> !host_err);
endmodule

bind ucode_ram_ctrl ucram_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .host_valid     (host_valid),
  .host_ready     (host_ready),
  .host_rsp_valid (host_rsp_valid),
  .host_rdata     (host_rdata),
  .host_err       (host_err),
  .cfg_disable    (cfg_disable),
  .emu_mode       (emu_mode),
  .freeze         (freeze),
  .stop_req       (stop_req),
  .stop_ack       (stop_ack),
  .eng_en         (eng_en),
  .eng0_data      (eng0_data),
  .eng1_data      (eng1_data)
);

// File: tb/tb_ucode_ram_ctrl.sv
module tb_ucode_ram_ctrl;
  localparam int AW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_valid = 1'b0;
  logic          host_ready;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_rsp_valid;
  logic [DW-1:0] host_rdata;
  logic          host_err;
  logic          cfg_disable = 1'b0;
  logic [1:0]    emu_mode = 2'b00;
  logic          freeze = 1'b0;
  logic          stop_req = 1'b0;
  logic          stop_ack;
  logic [1:0]    eng_en = 2'b00;
  logic [AW-1:0] eng0_addr = '0;
  logic [AW-1:0] eng1_addr = '0;
  logic [DW-1:0] eng0_data;
  logic [DW-1:0] eng1_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    string         req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  ucode_ram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pop and compare each response as it appears.
  always @(negedge clk) begin
    if (!rst && host_rsp_valid) begin
      if (sb.size() == 0) begin
        check("R2", "unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "rsp data", {16'h0, host_rdata}, {16'h0, e.data});
        check(e.req, "rsp err", {31'h0, host_err}, {31'h0, e.err});
      end
    end
  end

  // Driver: one host transfer, expectation pushed to the scoreboard.
  task automatic host_op(logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                         logic [DW-1:0] exp_d, logic exp_e, string req);
    exp_t e;
    @(negedge clk);
    host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    e.data = exp_d; e.err = exp_e; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic eng_fetch(logic [1:0] en, logic [AW-1:0] a0, logic [AW-1:0] a1,
                           logic [DW-1:0] e0, logic [DW-1:0] e1, string req);
    @(negedge clk);
    eng_en = en; eng0_addr = a0; eng1_addr = a1;
    @(negedge clk);
    check(req, "eng0 data", {16'h0, eng0_data}, {16'h0, e0});
    check(req, "eng1 data", {16'h0, eng1_data}, {16'h0, e1});
    eng_en = 2'b00;
  endtask

  task automatic step_ack(logic exp, string req);
    @(negedge clk);
    check(req, "stop_ack", {31'h0, stop_ack}, {31'h0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "ready in reset", {31'h0, host_ready}, 32'd0);
    check("R1", "rsp in reset", {31'h0, host_rsp_valid}, 32'd0);
    check("R1", "err in reset", {31'h0, host_err}, 32'd0);
    check("R1", "ack in reset", {31'h0, stop_ack}, 32'd0);
    check("R1", "eng in reset", {eng0_data, eng1_data}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "ready after reset", {31'h0, host_ready}, 32'd1);

    // R2 write then read back, boundaries of the address space
    host_op(1, 10'd5,    16'h1234, 16'h0, 0, "R2");
    host_op(1, 10'd1023, 16'hBEEF, 16'h0, 0, "R2");
    host_op(1, 10'd0,    16'h0001, 16'h0, 0, "R2");
    host_op(0, 10'd5,    16'h0, 16'h1234, 0, "R2");
    host_op(0, 10'd1023, 16'h0, 16'hBEEF, 0, "R2");
    host_op(0, 10'd0,    16'h0, 16'h0001, 0, "R2");

    // R11 freeze: host still works
    freeze = 1'b1;
    host_op(1, 10'd7, 16'h7777, 16'h0, 0, "R11");
    host_op(0, 10'd7, 16'h0, 16'h7777, 0, "R11");

    // R4 disable bit refuses host traffic
    cfg_disable = 1'b1;
    host_op(1, 10'd5, 16'hDEAD, 16'h0, 1, "R4");
    host_op(0, 10'd5, 16'h0, 16'h0, 1, "R4");
    cfg_disable = 1'b0;
    host_op(0, 10'd5, 16'h0, 16'h1234, 0, "R4");

    // R3 either or both engines owning the array
    emu_mode = 2'b01;
    host_op(1, 10'd5, 16'hFFFF, 16'h0, 1, "R3");
    host_op(0, 10'd5, 16'h0, 16'h0, 1, "R3");
    emu_mode = 2'b10;
    host_op(1, 10'd0, 16'hAAAA, 16'h0, 1, "R3");
    emu_mode = 2'b11;
    host_op(0, 10'd1023, 16'h0, 16'h0, 1, "R3");

    // R6 / R5 / R11 simultaneous engine fetches with disable and freeze set
    cfg_disable = 1'b1;
    eng_fetch(2'b11, 10'd5, 10'd1023, 16'h1234, 16'hBEEF, "R6");
    eng_fetch(2'b11, 10'd7, 10'd0, 16'h7777, 16'h0001, "R5");
    cfg_disable = 1'b0;
    freeze = 1'b0;

    // R7 engine without its emulation bit or enable reads zero
    emu_mode = 2'b01;
    eng_fetch(2'b11, 10'd0, 10'd5, 16'h0001, 16'h0, "R7");
    emu_mode = 2'b11;
    eng_fetch(2'b10, 10'd5, 10'd7, 16'h0, 16'h7777, "R7");

    // R3 dropped writes left the array intact
    emu_mode = 2'b00;
    host_op(0, 10'd5, 16'h0, 16'h1234, 0, "R3");
    host_op(0, 10'd0, 16'h0, 16'h0001, 0, "R3");

    // R9 stop refused during emulation
    emu_mode = 2'b10;
    stop_req = 1'b1;
    step_ack(0, "R9");
    step_ack(0, "R9");
    emu_mode = 2'b00;
    step_ack(1, "R9");

    // R8 release and re-entry timing
    stop_req = 1'b0;
    step_ack(0, "R8");
    stop_req = 1'b1;
    step_ack(1, "R8");
    step_ack(1, "R8");

    // R10 stopped array rejects everything
    host_op(1, 10'd5, 16'h5555, 16'h0, 1, "R10");
    host_op(0, 10'd5, 16'h0, 16'h0, 1, "R10");
    emu_mode = 2'b11;
    step_ack(1, "R10");
    eng_fetch(2'b11, 10'd5, 10'd1023, 16'h0, 16'h0, "R10");
    emu_mode = 2'b00;
    stop_req = 1'b0;
    step_ack(0, "R10");
    host_op(0, 10'd5, 16'h0, 16'h1234, 0, "R10");

    repeat (3) @(negedge clk);
    check("R2", "scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule